// File: doc/BRIEF.md
# Delay-Code Programming Port

This block is the configuration front end of a programmable timing element. It holds the 8-bit code that sets the delay and offers two ways to load it over one shared set of pins. A mode-select input chooses the way. In parallel mode, eight data pins pass through a latch. The latch follows the pins while the enable is high and holds its value while the enable is low. In serial mode, the enable, a serial clock and a serial data pin form a 3-wire shift interface. The bits shift into an internal register, and the new code is committed when the enable falls.

The serial-out pin always shows the most significant bit of the shift register. Several ports can therefore be chained, with each port's serial-out feeding the next port's serial-in. A chain of three ports needs 24 serial clocks per transfer. The stored value can also be read back through the same pin. The read leaves the value intact only if the host loops serial-out back into serial-in while it shifts. Otherwise the read overwrites the value.

All pin inputs are asynchronous to the system clock. Each passes through a two-flop synchroniser, and clock and enable edges are found on the synchronised copies. A settled flag drops on every change of the active code. It rises again a programmable number of system cycles later, and the delay path treats the code as valid only from that point.

Top module: `dly_code_port`

## Requirements
- R1: When the mode-select input is 0, the block is in parallel mode. When it is 1, the block is in serial mode. In serial mode the parallel pins have no effect on the active code.
- R2: In parallel mode, the active code follows the parallel pins while the enable is high. It holds its value while the enable is low. A pin change reaches the code on the third rising system clock edge after it is applied.
- R3: In serial mode, each rising edge of the synchronised serial clock shifts the synchronised data bit into bit 0 of the shift register while the enable is high. Bits arrive most significant first. Serial clock edges seen while the enable is low change neither the shift register nor the code.
- R4: In serial mode, the active code stays unchanged while bits are shifted. It takes the shift register's value on the falling edge of the synchronised enable.
- R5: The serial-out pin always equals bit 7 (the most significant bit) of the shift register. Shifting N further bits therefore presents the previous contents most significant bit first, so a chain of ports forms one long shift register.
- R6: Looping serial-out back to serial-in for eight serial clocks, then committing, leaves the code unchanged. Shifting in other data overwrites the value: after k zero bits and a commit, the code is the old code shifted left by k.
- R7: The settled flag goes low in the same cycle that the active code changes. It rises exactly SETTLE_CYC cycles later if no further change occurs. A load that writes the same value does not drop it.
- R8: After reset, the active code is 0, the serial-out pin is 0 and the settled flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | 0 selects parallel loading, 1 selects serial loading |
| load_en | input | 1 | Latch enable (parallel) or transfer enable (serial) |
| par_code | input | 8 | Parallel code pins |
| ser_clk | input | 1 | Serial shift clock |
| ser_din | input | 1 | Serial data in |
| ser_dout | output | 1 | Serial data out, most significant bit of the shift register |
| code_o | output | 8 | Active delay code |
| settled_o | output | 1 | High once the settling interval after the last code change has elapsed |

## Verification
Every pin reaches the logic two system edges after it is applied, so a parallel load, a serial shift or a commit shows at the outputs on the third rising edge after the stimulus. The settled flag then rises SETTLE_CYC edges after that. The bench's reference model delays its copy of the inputs by the same two edges and compares the code, the serial-out pin and the settled flag at every falling clock edge. Directed checks are placed only after waits of at least four cycles.

// File: rtl/dcp_pkg.sv
// Package: shared types for the delay-code programming port.
// Assumes the bundle of control pins is synchronised as one vector.
package dcp_pkg;
    typedef struct packed {
        logic mode;   // 1 = serial loading
        logic en;     // latch / transfer enable
        logic sck;    // serial clock
        logic sdi;    // serial data
    } ctl_t;
    localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/dcp_sync.sv
// Module: dcp_sync
// Multi-stage synchroniser for a bundle of asynchronous pins.
// Assumes STAGES >= 2; all bits reset to 0.
module dcp_sync #(
    parameter int W      = 12,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st;

    // Shift the pin bundle through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= '0;
        else        st <= {st[STAGES-2:0], d};
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/dcp_loader.sv
// Module: dcp_loader
// Holds the shift register and the active code. In parallel mode it loads both
// while the enable is high. In serial mode it shifts on serial clock rises and
// commits on the enable's fall. Assumes all inputs are already synchronous.
module dcp_loader #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_s,
    input  logic         en_s,
    input  logic         sck_s,
    input  logic         sdi_s,
    input  logic [W-1:0] par_s,
    output logic [W-1:0] code_o,
    output logic         sdo_o,
    output logic         upd_o
);
    logic         sck_d, en_d;
    logic         sck_rise, en_fall;
    logic [W-1:0] sreg_q, sreg_nx, code_q, code_nx;

    assign sck_rise = sck_s & ~sck_d;
    assign en_fall  = ~en_s & en_d;

    // Choose the next shift-register and code values from the mode and edges.
    always_comb begin
        sreg_nx = sreg_q;
        code_nx = code_q;
        if (!mode_s && en_s) begin
            sreg_nx = par_s;
            code_nx = par_s;
        end else if (mode_s && en_s && sck_rise) begin
            sreg_nx = {sreg_q[W-2:0], sdi_s};
        end else if (mode_s && en_fall) begin
            code_nx = sreg_q;
        end
    end

    // Register edge history, shift register and active code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            en_d   <= 1'b0;
            sreg_q <= '0;
            code_q <= '0;
        end else begin
            sck_d  <= sck_s;
            en_d   <= en_s;
            sreg_q <= sreg_nx;
            code_q <= code_nx;
        end
    end

    assign upd_o  = (code_nx != code_q);
    assign code_o = code_q;
    assign sdo_o  = sreg_q[W-1];

    assert_par_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_s && en_s) |=> (code_q == $past(par_s)));
    assert_shift_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && en_s && sck_rise) |=> (sreg_q[0] == $past(sdi_s)));
    assert_idle_ignore_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && !en_s && !en_d) |=> ($stable(sreg_q) && $stable(code_q)));
    assert_hold_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && en_s) |=> $stable(code_q));
    assert_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_s && en_fall) |=> (code_q == $past(sreg_q)));
endmodule

// File: rtl/dcp_settle.sv
// Module: dcp_settle
// Settling timer: reloads on every code update and counts down to zero.
// The settled flag is high while the count is zero. Assumes SETTLE_CYC >= 1.
module dcp_settle #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    output logic settled_o
);
    localparam int CW = $clog2(SETTLE_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYC);

    logic [CW-1:0] cnt;

    // Reload on update, otherwise count down until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt <= '0;
        else if (upd_i)     cnt <= LOAD;
        else if (cnt != '0) cnt <= cnt - 1'b1;
    end

    assign settled_o = (cnt == '0);

    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LOAD);
    assert_upd_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_i |=> !settled_o);
endmodule

// File: rtl/dly_code_port.sv
// Module: dly_code_port (top)
// Dual-mode programming port for the delay code: a transparent parallel latch
// or a chainable serial shift register, selected by mode_sel. Assumes all pins
// are asynchronous; each is synchronised before use.
module dly_code_port #(
    parameter int CODE_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETTLE_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_sel,
    input  logic              load_en,
    input  logic [CODE_W-1:0] par_code,
    input  logic              ser_clk,
    input  logic              ser_din,
    output logic              ser_dout,
    output logic [CODE_W-1:0] code_o,
    output logic              settled_o
);
    import dcp_pkg::*;
    localparam int BW = CTL_W + CODE_W;

    ctl_t              ctl_raw, ctl_s;
    logic [CODE_W-1:0] par_s;
    logic              upd;

    assign ctl_raw = '{mode: mode_sel, en: load_en, sck: ser_clk, sdi: ser_din};

    dcp_sync #(.W(BW), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ctl_raw, par_code}),
        .q     ({ctl_s, par_s})
    );

    dcp_loader #(.W(CODE_W)) u_load (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_s (ctl_s.mode),
        .en_s   (ctl_s.en),
        .sck_s  (ctl_s.sck),
        .sdi_s  (ctl_s.sdi),
        .par_s  (par_s),
        .code_o (code_o),
        .sdo_o  (ser_dout),
        .upd_o  (upd)
    );

    dcp_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_i     (upd),
        .settled_o (settled_o)
    );

    assert_reset_state_R8: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && settled_o && !ser_dout));
    assert_change_unsettled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(code_o) |-> !settled_o);
    assert_settle_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(settled_o) |-> $stable(code_o));
    assert_serial_ignores_par_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_s.mode && ctl_s.en) |=> $stable(code_o));
endmodule

// File: tb/sim_dly_code_port.sv
// Bench: behavioural reference model with a 2-edge input delay queue,
// compared at every falling edge, plus directed checks per requirement.
module sim_dly_code_port;
    localparam int SET = 16;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       mode_sel = 1'b0, load_en = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic [7:0] par_code = 8'h00;
    logic       ser_dout, settled_o;
    logic [7:0] code_o;

    int checks = 0, fails = 0;
    bit done = 1'b0, live = 1'b0;

    always #5 clk = ~clk;

    dly_code_port #(.CODE_W(8), .SYNC_STAGES(2), .SETTLE_CYC(SET)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .load_en(load_en),
        .par_code(par_code), .ser_clk(ser_clk), .ser_din(ser_din),
        .ser_dout(ser_dout), .code_o(code_o), .settled_o(settled_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference model: the inputs reach the logic two edges late.
    logic [11:0] hist[$];
    logic [11:0] cur, prv;
    logic [7:0]  m_code, m_sreg, nc;
    int          m_cnt;

    always @(posedge clk) begin
        live <= rst_n;
        if (!rst_n) begin
            hist = '{12'h0, 12'h0, 12'h0};
            m_code = 8'h00; m_sreg = 8'h00; m_cnt = 0;
        end else begin
            hist.push_back({mode_sel, load_en, ser_clk, ser_din, par_code});
            if (hist.size() > 4) void'(hist.pop_front());
            cur = hist[hist.size()-3];
            prv = hist[hist.size()-4];
            nc  = m_code;
            if (!cur[11] && cur[10]) begin
                nc = cur[7:0]; m_sreg = cur[7:0];
            end else if (cur[11] && cur[10] && cur[9] && !prv[9]) begin
                m_sreg = {m_sreg[6:0], cur[8]};
            end else if (cur[11] && !cur[10] && prv[10]) begin
                nc = m_sreg;
            end
            if (nc != m_code) begin
                m_code = nc; m_cnt = SET;
            end else if (m_cnt > 0) begin
                m_cnt--;
            end
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            chk("R2/R4 model code", code_o, m_code);
            chk("R5 model serial out", ser_dout, m_sreg[7]);
            chk("R7 model settled", settled_o, m_cnt == 0);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        ser_din = b; wait_cyc(4);
        ser_clk = 1'b1; wait_cyc(4);
        ser_clk = 1'b0; wait_cyc(4);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired (all requirements) actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] got;
        logic [15:0] stream;
        wait_cyc(3);
        chk("R8 reset code", code_o, 8'h00);
        chk("R8 reset settled", settled_o, 1'b1);
        chk("R8 reset serial out", ser_dout, 1'b0);
        rst_n = 1'b1;

        // R2: transparent latch, then hold
        load_en = 1'b1; par_code = 8'h5A; wait_cyc(4);
        chk("R2 parallel load", code_o, 8'h5A);
        chk("R7 settled low after change", settled_o, 1'b0);
        wait_cyc(SET + 2);
        chk("R7 settled high after interval", settled_o, 1'b1);
        load_en = 1'b0; wait_cyc(1); par_code = 8'hFF; wait_cyc(5);
        chk("R2 hold while enable low", code_o, 8'h5A);
        load_en = 1'b1; par_code = 8'hA5; wait_cyc(4);
        chk("R2 follows pins", code_o, 8'hA5);
        par_code = 8'h5A; wait_cyc(4);
        chk("R2 follows pins again", code_o, 8'h5A);
        load_en = 1'b0; wait_cyc(SET + 4);

        // R1: serial mode ignores parallel pins
        mode_sel = 1'b1; wait_cyc(3);
        load_en = 1'b1; par_code = 8'h11; wait_cyc(5);
        chk("R1 parallel pins ignored in serial mode", code_o, 8'h5A);
        load_en = 1'b0; wait_cyc(5);
        chk("R1 commit keeps latched value", code_o, 8'h5A);

        // R3: serial clocks with enable low are ignored
        for (int i = 0; i < 4; i++) sbit(1'b1);
        chk("R3 idle clocks leave code", code_o, 8'h5A);
        chk("R3 idle clocks leave register", ser_dout, 1'b0);

        // R4: shift and commit
        load_en = 1'b1; wait_cyc(4);
        for (int i = 7; i >= 0; i--) sbit(8'hC3 >> i);
        chk("R4 code held during shift", code_o, 8'h5A);
        chk("R5 serial out shows msb", ser_dout, 1'b1);
        load_en = 1'b0; wait_cyc(5);
        chk("R4 commit on enable fall", code_o, 8'hC3);
        wait_cyc(SET + 4);

        // R5: 16 bits through, like two chained ports
        stream = 16'h963C;
        load_en = 1'b1; wait_cyc(4);
        for (int j = 0; j < 16; j++) begin
            got[15-j] = ser_dout;
            sbit(stream[15-j]);
        end
        chk("R5 readback of old code", got[15:8], 8'hC3);
        chk("R5 chained first byte out", got[7:0], 8'h96);
        load_en = 1'b0; wait_cyc(5);
        chk("R4 last byte committed", code_o, 8'h3C);
        wait_cyc(SET + 4);

        // R6: loopback read keeps the value
        load_en = 1'b1; wait_cyc(4);
        for (int j = 0; j < 8; j++) sbit(ser_dout);
        load_en = 1'b0; wait_cyc(5);
        chk("R6 loopback read preserves code", code_o, 8'h3C);
        chk("R7 no drop on same value", settled_o, 1'b1);

        // R6: read without feedback is destructive
        load_en = 1'b1; wait_cyc(4);
        for (int j = 0; j < 4; j++) sbit(1'b0);
        load_en = 1'b0; wait_cyc(5);
        chk("R6 destructive read", code_o, 8'hC0);
        wait_cyc(SET + 4);
        chk("R7 settled after destructive write", settled_o, 1'b1);

        finish_run();
    end
endmodule